// File: doc/BRIEF.md
# Flash Controller Command and Interrupt Register Front End

This block is the register face of a NAND-style flash controller. A host writes 16-bit words over a simple register bus to set the start address registers, the buffer selection word, two configuration words and the command word. It reads back the same words plus an error status word and an interrupt status word. An accepted command goes to a downstream operation engine as a one-cycle strobe with the latched opcode. The engine reports each finished operation on a completion pulse with a kind code and a failure flag.

The interrupt status word has a master bit that gates new commands. The host acknowledges work by writing an AND mask to the interrupt word. When that mask drops the master bit, the latched error flags are also wiped. The interrupt pin polarity and the ready pin level come from the first configuration word. The block supports a cold reset on `rst_n` and a warm reset from a pin or from a dedicated opcode. The flash array, the data buffers and ECC are outside this block.

The register bus has one write strobe, a 4-bit word offset and a combinational read mux. The offsets are: 0x0 to 0x7 start addresses, 0x8 buffer selection, 0x9 command, 0xA configuration 1, 0xB configuration 2, 0xC error status (read only) and 0xD interrupt status. Offsets 0xE and 0xF read as zero and ignore writes. The completion pulse is a plain control input with no back-pressure. The engine must not hold it high for more than one cycle per finished operation.

Top module: `fc_flash_regs`

## Requirements
- R1: After cold reset the registers read as follows: configuration 1 reads 0x40C0 (stored 0x40C0), configuration 2 reads 0x0000, interrupt status reads 0x8080, error status reads 0x0000, all start addresses read 0x0000, the command word reads 0x0000 and the buffer word reads 0x0002. `rdy_o` is 1 and `cmd_vld_o` is 0.
- R2: Warm reset is triggered by `warm_rst_i` or by an accepted command write of opcode 0x00F3. It restores every R1 value except two: interrupt status becomes 0x8010, and the command word keeps its value. While `warm_rst_i` is high, bus writes and completions in that cycle are discarded. A warm reset issues no strobe.
- R3: The eight start address registers at offsets 0x0 to 0x7 store and read back all 16 bits.
- R4: A write to offset 0x8 sets the buffer field from data bits 11:8 and the count from data bits 1:0, where 0 means 4. The word reads back as (buffer << 8) | ((count - 1) & 2).
- R5: Configuration 1 reads back with bits 4:0 forced to zero. Configuration 2 reads back all 16 bits.
- R6: A write to configuration 1 sets `rdy_o` to data bit 7 from the next cycle onward.
- R7: `intr_o` equals interrupt-status bit 15 XOR the inverse of configuration-1 bit 6 at all times.
- R8: A write to offset 0xD replaces the interrupt status with the old status AND the written data. If bit 15 of the result is 0, error status bits 13:10 clear as well. Error bits are never set while interrupt bit 15 is 0.
- R9: A command write while interrupt bit 15 is 1 is ignored. There is no strobe, the command word does not change and no status changes.
- R10: An accepted command write with a recognised opcode latches the opcode. The opcode reads back at offset 0x9 and drives `cmd_vld_o` for exactly one cycle after the write, with `cmd_op_o` equal to the opcode. The recognised opcodes are 0x0000, 0x0013, 0x0080, 0x001A, 0x001B, 0x0023, 0x0027, 0x002A, 0x002C, 0x0071, 0x0095, 0x0094, 0x00B0, 0x0030, 0x00F0, 0x0065 and 0x00F3 (the last one is handled per R2).
- R11: An accepted command write with any other opcode latches the opcode but issues no strobe. It sets error bit 10 and interrupt bit 15.
- R12: A completion pulse sets interrupt bit 15 plus a bit chosen by `done_kind_i`: kind 0 sets bit 5 (erase), kind 1 sets bit 6 (program), kind 2 sets bit 7 (load) and kind 3 sets no extra bit. If `done_fail_i` is high, error bit 10 is set, plus bit 11, 12 or 13 for kinds 0, 1 or 2.
- R13: When a completion and an interrupt-status write fall in the same cycle, the mask is applied to the old status first and the completion bits are then ORed in. The errors therefore survive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst_i | input | 1 | Synchronous warm reset request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word offset (read and write) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for `reg_addr_i` |
| done_i | input | 1 | Operation completion pulse from the engine |
| done_kind_i | input | 2 | Completion kind: 0 erase, 1 program, 2 load, 3 other |
| done_fail_i | input | 1 | Completed operation failed |
| cmd_vld_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 16 | Latched opcode |
| intr_o | output | 1 | Interrupt pin, polarity from configuration 1 |
| rdy_o | output | 1 | Ready pin |

## Verification
The engine's completion pulse and the host's interrupt-status AND write can land in the same clock edge. Their order decides whether error flags survive. The bench forces this collision in a directed case: a failing erase completion arrives together with an all-zero mask. The expected result is a status of exactly the erase bit plus the master bit, with both error bits kept. The random phase drives completions and bus writes independently, so the collision recurs with mixed kinds and masks. Every such cycle is judged against a bench model that masks first and ORs second.

// File: rtl/fc_front_pkg.sv
package fc_front_pkg;
  localparam int DW = 16;

  localparam logic [3:0] OFS_BUF  = 4'h8;
  localparam logic [3:0] OFS_CMD  = 4'h9;
  localparam logic [3:0] OFS_CFG1 = 4'hA;
  localparam logic [3:0] OFS_CFG2 = 4'hB;
  localparam logic [3:0] OFS_STAT = 4'hC;
  localparam logic [3:0] OFS_INT  = 4'hD;

  localparam int INT_MASTER = 15;
  localparam int INT_ERASE  = 5;
  localparam int INT_PROG   = 6;
  localparam int INT_LOAD   = 7;

  localparam int ERR_LSB = 10;
  localparam int ERR_W   = 4;

  localparam logic [DW-1:0] CFG1_RST  = 16'h40C0;
  localparam logic [DW-1:0] INT_COLD  = 16'h8080;
  localparam logic [DW-1:0] INT_WARM  = 16'h8010;
  localparam logic [DW-1:0] OP_HOTRST = 16'h00F3;

  typedef enum logic [1:0] {
    DK_ERASE = 2'd0,
    DK_PROG  = 2'd1,
    DK_LOAD  = 2'd2,
    DK_MISC  = 2'd3
  } done_kind_e;

  function automatic logic op_known(input logic [DW-1:0] op);
    case (op)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B, 16'h0023,
      16'h0027, 16'h002A, 16'h002C, 16'h0071, 16'h0095, 16'h0094,
      16'h00B0, 16'h0030, 16'h00F0, 16'h0065, 16'h00F3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fc_cfg_bank.sv
module fc_cfg_bank
  import fc_front_pkg::*;
#(
  parameter int N_SA = 8,
  parameter int AW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 warm,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [N_SA-1:0][DW-1:0] sa_q,
  output logic [DW-1:0]        buf_rd,
  output logic [DW-1:0]        cfg1_q,
  output logic [DW-1:0]        cfg2_q,
  output logic                 rdy_q
);
  localparam int BUF_W = 4;
  localparam int CNT_W = 3;

  logic [BUF_W-1:0] bufa_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_m1;
  logic [CNT_W-1:0] cnt_dec;

  assign cnt_dec = (wdata[1:0] == 2'd0) ? CNT_W'(4) : {1'b0, wdata[1:0]};
  assign cnt_m1  = cnt_q - CNT_W'(1);
  assign buf_rd  = {4'h0, bufa_q, 8'h00} | {14'h0, cnt_m1[1], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= '0;
    end else if (warm) begin
      sa_q <= '0;
    end else begin
      for (int i = 0; i < N_SA; i++) begin
        if (wr && addr == AW'(i)) sa_q[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufa_q <= '0;
      cnt_q  <= CNT_W'(4);
      cfg1_q <= CFG1_RST;
      cfg2_q <= '0;
      rdy_q  <= 1'b1;
    end else if (warm) begin
      bufa_q <= '0;
      cnt_q  <= CNT_W'(4);
      cfg1_q <= CFG1_RST;
      cfg2_q <= '0;
      rdy_q  <= 1'b1;
    end else if (wr) begin
      if (addr == OFS_BUF) begin
        bufa_q <= wdata[11:8];
        cnt_q  <= cnt_dec;
      end
      if (addr == OFS_CFG1) begin
        cfg1_q <= wdata;
        rdy_q  <= wdata[7];
      end
      if (addr == OFS_CFG2) cfg2_q <= wdata;
    end
  end

  // R2
  warm_cfg1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |=> (cfg1_q == CFG1_RST && rdy_q));

  // R6
  rdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_CFG1 && !warm) |=> (rdy_q == $past(wdata[7])));
endmodule

// File: rtl/fc_cmd_gate.sv
module fc_cmd_gate
  import fc_front_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_pin,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  input  logic          master,
  output logic [DW-1:0] cmd_q,
  output logic          vld_q,
  output logic          bad,
  output logic          hot_rst
);
  logic accept;

  assign accept  = wr_cmd && !master && !warm_pin;
  assign bad     = accept && !op_known(wdata);
  assign hot_rst = accept && (wdata == OP_HOTRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= accept && op_known(wdata) && (wdata != OP_HOTRST);
      if (accept) cmd_q <= wdata;
    end
  end

  // R9
  blocked_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && master) |=> (!vld_q && $stable(cmd_q)));

  // R10
  strobe_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($past(wr_cmd) && cmd_q == $past(wdata)));
endmodule

// File: rtl/fc_irq_status.sv
module fc_irq_status
  import fc_front_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm,
  input  logic          int_wr,
  input  logic [DW-1:0] wdata,
  input  logic          bad_cmd,
  input  logic          done,
  input  done_kind_e    dkind,
  input  logic          dfail,
  output logic [DW-1:0] int_q,
  output logic [DW-1:0] stat_q,
  output logic          master
);
  localparam int STAT_HI = DW - ERR_LSB - ERR_W;

  logic [ERR_W-1:0] err_q, nxt_err;
  logic [DW-1:0]    nxt_int;

  always_comb begin
    nxt_int = int_q;
    nxt_err = err_q;
    if (int_wr) nxt_int = nxt_int & wdata;
    if (bad_cmd) begin
      nxt_int[INT_MASTER] = 1'b1;
      nxt_err[0]          = 1'b1;
    end
    if (done) begin
      nxt_int[INT_MASTER] = 1'b1;
      if (dfail) nxt_err[0] = 1'b1;
      case (dkind)
        DK_ERASE: begin nxt_int[INT_ERASE] = 1'b1; if (dfail) nxt_err[1] = 1'b1; end
        DK_PROG:  begin nxt_int[INT_PROG]  = 1'b1; if (dfail) nxt_err[2] = 1'b1; end
        DK_LOAD:  begin nxt_int[INT_LOAD]  = 1'b1; if (dfail) nxt_err[3] = 1'b1; end
        default:  ;
      endcase
    end
    if (!nxt_int[INT_MASTER]) nxt_err = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= INT_COLD;
      err_q <= '0;
    end else if (warm) begin
      int_q <= INT_WARM;
      err_q <= '0;
    end else begin
      int_q <= nxt_int;
      err_q <= nxt_err;
    end
  end

  assign master = int_q[INT_MASTER];
  assign stat_q = {{STAT_HI{1'b0}}, err_q, {ERR_LSB{1'b0}}};

  // R12
  done_sets_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> int_q[INT_MASTER]);

  // R8
  err_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_q[INT_MASTER] |-> (err_q == '0));

  // R8
  and_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_wr && !warm && !done && !bad_cmd) |=> ((int_q & ~$past(wdata)) == '0));
endmodule

// File: rtl/fc_flash_regs.sv
module fc_flash_regs
  import fc_front_pkg::*;
#(
  parameter int AW   = 4,
  parameter int N_SA = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_rst_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [15:0]   reg_wdata_i,
  output logic [15:0]   reg_rdata_o,
  input  logic          done_i,
  input  logic [1:0]    done_kind_i,
  input  logic          done_fail_i,
  output logic          cmd_vld_o,
  output logic [15:0]   cmd_op_o,
  output logic          intr_o,
  output logic          rdy_o
);
  logic [N_SA-1:0][DW-1:0] sa_q;
  logic [DW-1:0] buf_rd, cfg1_q, cfg2_q, int_q, stat_q, cmd_q;
  logic          rdy_q, master, bad, hot_rst, warm_all, cmd_wr, int_wr;

  assign cmd_wr   = reg_wr_i && (reg_addr_i == AW'(OFS_CMD));
  assign int_wr   = reg_wr_i && (reg_addr_i == AW'(OFS_INT));
  assign warm_all = warm_rst_i || hot_rst;

  fc_cfg_bank #(.N_SA(N_SA), .AW(AW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .warm   (warm_all),
    .wr     (reg_wr_i),
    .addr   (reg_addr_i),
    .wdata  (reg_wdata_i),
    .sa_q   (sa_q),
    .buf_rd (buf_rd),
    .cfg1_q (cfg1_q),
    .cfg2_q (cfg2_q),
    .rdy_q  (rdy_q)
  );

  fc_cmd_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .warm_pin (warm_rst_i),
    .wr_cmd   (cmd_wr),
    .wdata    (reg_wdata_i),
    .master   (master),
    .cmd_q    (cmd_q),
    .vld_q    (cmd_vld_o),
    .bad      (bad),
    .hot_rst  (hot_rst)
  );

  fc_irq_status u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .warm    (warm_all),
    .int_wr  (int_wr),
    .wdata   (reg_wdata_i),
    .bad_cmd (bad),
    .done    (done_i),
    .dkind   (done_kind_e'(done_kind_i)),
    .dfail   (done_fail_i),
    .int_q   (int_q),
    .stat_q  (stat_q),
    .master  (master)
  );

  assign cmd_op_o = cmd_q;
  assign rdy_o    = rdy_q;
  assign intr_o   = int_q[INT_MASTER] ^ ~cfg1_q[6];

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < N_SA; i++) begin
      if (reg_addr_i == AW'(i)) reg_rdata_o = sa_q[i];
    end
    case (reg_addr_i)
      AW'(OFS_BUF):  reg_rdata_o = buf_rd;
      AW'(OFS_CMD):  reg_rdata_o = cmd_q;
      AW'(OFS_CFG1): reg_rdata_o = cfg1_q & 16'hFFE0;
      AW'(OFS_CFG2): reg_rdata_o = cfg2_q;
      AW'(OFS_STAT): reg_rdata_o = stat_q;
      AW'(OFS_INT):  reg_rdata_o = int_q;
      default: ;
    endcase
  end
endmodule

// File: tb/fc_flash_regs_tb.sv
`timescale 1ns/100ps
module fc_flash_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_rst_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_addr_i = 4'h0;
  logic [15:0] reg_wdata_i = 16'h0;
  logic [15:0] reg_rdata_o;
  logic        done_i = 1'b0;
  logic [1:0]  done_kind_i = 2'd0;
  logic        done_fail_i = 1'b0;
  logic        cmd_vld_o;
  logic [15:0] cmd_op_o;
  logic        intr_o, rdy_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fc_flash_regs u_dut (
    .clk(clk), .rst_n(rst_n), .warm_rst_i(warm_rst_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .done_i(done_i), .done_kind_i(done_kind_i), .done_fail_i(done_fail_i),
    .cmd_vld_o(cmd_vld_o), .cmd_op_o(cmd_op_o), .intr_o(intr_o), .rdy_o(rdy_o)
  );

  // Bench model of the register state, updated from the requirements
  logic [15:0] m_sa [8];
  logic [3:0]  m_bufa;
  logic [2:0]  m_cnt;
  logic [15:0] m_cmd, m_cfg1, m_cfg2, m_int, m_err;
  logic        m_rdy, m_vld;

  function automatic bit known_op(input logic [15:0] op);
    logic [15:0] list [17] = '{16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071, 16'h0095, 16'h0094,
      16'h00B0, 16'h0030, 16'h00F0, 16'h0065, 16'h00F3};
    for (int i = 0; i < 17; i++) if (list[i] == op) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_regs_reset(input logic [15:0] ival);
    for (int i = 0; i < 8; i++) m_sa[i] = 16'h0;
    m_bufa = 4'h0; m_cnt = 3'd4; m_cfg1 = 16'h40C0; m_cfg2 = 16'h0;
    m_int = ival; m_err = 16'h0; m_rdy = 1'b1; m_vld = 1'b0;
  endtask

  task automatic model_step(input bit wr, input logic [3:0] a, input logic [15:0] d,
                            input bit dn, input logic [1:0] k, input bit fl, input bit wp);
    bit hot;
    hot = 0;
    m_vld = 1'b0;
    if (wp) begin
      model_regs_reset(16'h8010);
      return;
    end
    if (wr) begin
      case (a)
        4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7: m_sa[a[2:0]] = d;
        4'h8: begin m_bufa = d[11:8]; m_cnt = (d[1:0] == 2'd0) ? 3'd4 : {1'b0, d[1:0]}; end
        4'h9: if (!m_int[15]) begin
          m_cmd = d;
          if (d == 16'h00F3) hot = 1;
          else if (known_op(d)) m_vld = 1'b1;
          else begin m_err = m_err | 16'h0400; m_int = m_int | 16'h8000; end
        end
        4'hA: begin m_cfg1 = d; m_rdy = d[7]; end
        4'hB: m_cfg2 = d;
        4'hD: m_int = m_int & d;
        default: ;
      endcase
    end
    if (hot) begin
      model_regs_reset(16'h8010);
      return;
    end
    if (dn) begin
      m_int = m_int | 16'h8000;
      if (fl) m_err = m_err | 16'h0400;
      case (k)
        2'd0: begin m_int = m_int | 16'h0020; if (fl) m_err = m_err | 16'h0800; end
        2'd1: begin m_int = m_int | 16'h0040; if (fl) m_err = m_err | 16'h1000; end
        2'd2: begin m_int = m_int | 16'h0080; if (fl) m_err = m_err | 16'h2000; end
        default: ;
      endcase
    end
    if (!m_int[15]) m_err = 16'h0;
  endtask

  function automatic logic [15:0] exp_rd(input logic [3:0] a);
    logic [2:0] c;
    c = m_cnt - 3'd1;
    case (a)
      4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7: return m_sa[a[2:0]];
      4'h8: return {4'h0, m_bufa, 8'h00} | {14'h0, c[1], 1'b0};
      4'h9: return m_cmd;
      4'hA: return m_cfg1 & 16'hFFE0;
      4'hB: return m_cfg2;
      4'hC: return m_err;
      4'hD: return m_int;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pins(input string tag);
    check16({tag, " cmd_vld"}, {15'h0, cmd_vld_o}, {15'h0, m_vld});
    if (m_vld) check16({tag, " cmd_op"}, cmd_op_o, m_cmd);
    // R7 polarity rule
    check16({tag, " R7 intr"}, {15'h0, intr_o}, {15'h0, m_int[15] ^ ~m_cfg1[6]});
    check16({tag, " R6 rdy"}, {15'h0, rdy_o}, {15'h0, m_rdy});
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 16; a++) begin
      reg_addr_i = 4'(a);
      #0.1;
      check16($sformatf("%s read %0h", tag, a), reg_rdata_o, exp_rd(4'(a)));
    end
  endtask

  task automatic cyc(input string tag, input bit wr, input logic [3:0] a, input logic [15:0] d,
                     input bit dn = 0, input logic [1:0] k = 2'd0, input bit fl = 0,
                     input bit wp = 0);
    @(negedge clk);
    reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
    done_i = dn; done_kind_i = k; done_fail_i = fl; warm_rst_i = wp;
    @(posedge clk);
    model_step(wr, a, d, dn, k, fl, wp);
    @(negedge clk);
    reg_wr_i = 0; done_i = 0; done_fail_i = 0; warm_rst_i = 0;
    check_pins(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_regs_reset(16'h8080);
    m_cmd = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check_pins("R1 reset");
    read_all("R1 reset");

    // R9 command blocked while master bit set
    cyc("R9 blocked", 1, 4'h9, 16'h0080);
    read_all("R9 blocked");
    // R8 mask clears master and errors
    cyc("R8 clear", 1, 4'hD, 16'h7FFF);
    read_all("R8 clear");
    // R10 accepted opcode strobes once
    cyc("R10 strobe", 1, 4'h9, 16'h0080);
    cyc("R10 one cycle", 0, 4'h0, 16'h0);
    read_all("R10");
    // R11 unknown opcode
    cyc("R11 bad op", 1, 4'h9, 16'h00AB);
    read_all("R11");
    cyc("R8 ack", 1, 4'hD, 16'h0000);
    read_all("R8 ack");
    // R12 completions
    cyc("R12 prog fail", 0, 4'h0, 16'h0, 1, 2'd1, 1);
    read_all("R12 prog fail");
    cyc("R8 ack2", 1, 4'hD, 16'h0000);
    cyc("R12 load ok", 0, 4'h0, 16'h0, 1, 2'd2, 0);
    read_all("R12 load ok");
    cyc("R12 misc fail", 0, 4'h0, 16'h0, 1, 2'd3, 1);
    read_all("R12 misc fail");
    // R13 collision: completion with zero mask
    cyc("R13 collide", 1, 4'hD, 16'h0000, 1, 2'd0, 1);
    check16("R13 int", m_int, 16'h8020);
    check16("R13 err", m_err, 16'h0C00);
    read_all("R13 collide");
    cyc("R8 ack3", 1, 4'hD, 16'h0000);
    // R3 start addresses
    for (int i = 0; i < 8; i++) cyc("R3 sa", 1, 4'(i), 16'hA5C0 ^ 16'(i * 16'h1111));
    read_all("R3 sa");
    // R4 buffer encodings
    cyc("R4 buf", 1, 4'h8, 16'h0A03); read_all("R4 cnt3");
    cyc("R4 buf", 1, 4'h8, 16'h0501); read_all("R4 cnt1");
    cyc("R4 buf", 1, 4'h8, 16'hFF00); read_all("R4 cnt4");
    cyc("R4 buf", 1, 4'h8, 16'h0302); read_all("R4 cnt2");
    // R5 R6 R7 configuration
    cyc("R6 cfg1 zero", 1, 4'hA, 16'h0000); read_all("R5 cfg1 zero");
    cyc("R6 cfg1 ones", 1, 4'hA, 16'hFFFF); read_all("R5 cfg1 ones");
    cyc("R5 cfg2", 1, 4'hB, 16'hBEEF); read_all("R5 cfg2");
    cyc("R7 master", 0, 4'h0, 16'h0, 1, 2'd3, 0);
    cyc("R6 cfg1 lo", 1, 4'hA, 16'h0040); read_all("R7 pol");
    // R2 warm reset by pin, write in same cycle discarded
    cyc("R2 pin", 1, 4'hB, 16'h1234, 1, 2'd1, 1, 1);
    read_all("R2 pin");
    // R2 warm reset by opcode
    cyc("R8 ack4", 1, 4'hD, 16'h0000);
    cyc("R2 hot", 1, 4'h9, 16'h00F3);
    read_all("R2 hot");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  a;
      logic [15:0] d;
      bit wr, dn, fl, wp;
      logic [1:0] k;
      a  = 4'($urandom_range(0, 15));
      wr = ($urandom_range(0, 3) != 0);
      d  = 16'($urandom);
      if (a == 4'h9 && $urandom_range(0, 1) == 1) d = {8'h00, d[7:0] & 8'h3F};
      if (a == 4'h9 && d == 16'h00F3 && $urandom_range(0, 3) != 0) d = 16'h0094;
      if (a == 4'hD && $urandom_range(0, 1) == 1) d[15] = 1'b0;
      dn = ($urandom_range(0, 4) == 0);
      k  = 2'($urandom);
      fl = ($urandom_range(0, 1) == 1);
      wp = ($urandom_range(0, 99) == 0);
      cyc("R12 R13 random", wr, a, d, dn, k, fl, wp);
      if (n % 8 == 0) read_all("R3 R8 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule